// File: doc/BRIEF.md
# Dynamic Branch Predictor with Target Buffer

This block sits beside the fetch stage and, for every fetched address, says whether the next fetch should follow a branch and where it should go. The fetch stage supplies the address, a branch-kind hint and the displacement taken from early decode. The answer comes back combinationally in the same cycle. It covers both the direction (taken or not) and the next fetch address: the branch target when taken, the fall-through address (PC + 4) when not.

Three structures work together:
- A table of 2-bit saturating counters, indexed by the low word-address bits of the PC, holds the learned direction of conditional branches.
- A tagged, direct-mapped target buffer remembers the targets of taken branches.
- A small circular return stack predicts the targets of return instructions.

When a conditional branch misses in the target buffer, a static rule decides: backward branches are taken and forward branches are not. The execute stage reports every resolved branch on an update port, which trains the tables. In the same cycle the port raises a redirect with the corrected address whenever the earlier prediction was wrong.

Top module: `bpred_top`

## Requirements
- R1: After reset every direction counter holds 2'b01 (weakly not-taken), every target-buffer entry is invalid and the return stack is empty. A single taken update of a conditional branch is therefore enough to make its next prediction taken.
- R2: Kind codes are 0 none, 1 conditional, 2 jump, 3 call, 4 return. A conditional fetch that misses the target buffer predicts taken exactly when the displacement's sign bit is 1, with target PC + displacement. Whenever the prediction is not taken, the predicted next address is PC + 4.
- R3: Each counter increments on a taken conditional update and decrements on a not-taken one, saturating at 0 and 3. On a target-buffer hit, a conditional prediction is taken when the counter is 2 or 3.
- R4: After two taken outcomes, a single not-taken outcome leaves the prediction taken; a second one turns it not-taken.
- R5: A taken update of kind 1 to 4 writes the target and the PC tag into the buffer entry selected by PC bits [log2(entries)+1:2]. A fetch whose stored tag matches gets that target in the same cycle. A fetch whose tag differs is treated as a miss.
- R6: Jumps and calls are always predicted taken, with the buffered target on a hit and PC + displacement on a miss.
- R7: A call fetch pushes PC + 4 onto the return stack. A return fetch pops it and predicts taken to the popped address, so nested calls return in last-in, first-out order.
- R8: A push onto a full stack discards the oldest address. A return that finds the stack empty predicts taken to the buffered target on a hit, and not taken otherwise.
- R9: In the cycle of a valid update, a redirect is raised when the resolved direction differs from the predicted one, or when both are taken and the targets differ. The redirect address is the resolved target if taken, and update PC + 4 if not. Otherwise there is no redirect.
- R10: A fetch of kind 0 is predicted not taken and leaves the return stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_pc | input | PC_W | Address being fetched |
| fetch_kind | input | 3 | Branch-kind hint from early decode |
| fetch_disp | input | PC_W | Signed displacement of a direct branch |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is reported |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_kind | input | 3 | Kind of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | PC_W | Resolved target |
| upd_pred_taken | input | 1 | Direction predicted earlier for it |
| upd_pred_target | input | PC_W | Target predicted earlier for it |
| redirect_valid | output | 1 | Misprediction detected |
| redirect_pc | output | PC_W | Corrected fetch address |

## Verification
The assertions check several rules on every cycle:
- No-branch fetches are never taken, and jumps and calls always are.
- Any not-taken prediction points at PC + 4.
- A return fetched right after a call targets that call's PC + 4.
- Redirects occur only alongside a valid update.

Counter hysteresis and saturation, tag aliasing, stack overflow and empty-stack returns all depend on the history of several updates. These are shown only by the bench's directed sequences and by its long random run compared against an independent model.

// File: rtl/bpred_pkg.sv
// Shared definitions for the branch predictor.
package bpred_pkg;
    // Branch-kind hint codes carried by the fetch and update ports.
    typedef enum logic [2:0] {
        BK_NONE = 3'd0,
        BK_COND = 3'd1,
        BK_JUMP = 3'd2,
        BK_CALL = 3'd3,
        BK_RET  = 3'd4
    } br_kind_e;
endpackage

// File: rtl/bpred_dir.sv
// Direction table of 2-bit saturating counters.
// Assumes: ENTRIES is a power of two; the caller supplies word-address index bits.
module bpred_dir #(
    parameter int ENTRIES = 256,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_taken,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_taken
);
    logic [1:0] ctr [ENTRIES];

    // Read the prediction bit (counter MSB) for the fetch index.
    assign rd_taken = ctr[rd_idx][1];

    // Reset all counters to weakly not-taken; train one counter per update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ctr[i] <= 2'b01;
        end else if (wr_en) begin
            if (wr_taken && ctr[wr_idx] != 2'b11)
                ctr[wr_idx] <= ctr[wr_idx] + 2'b01;
            else if (!wr_taken && ctr[wr_idx] != 2'b00)
                ctr[wr_idx] <= ctr[wr_idx] - 2'b01;
        end
    end
endmodule

// File: rtl/bpred_btb.sv
// Direct-mapped, tagged branch target buffer.
// Assumes: ENTRIES is a power of two; index and tag slices come from the caller.
module bpred_btb #(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 32,
    localparam int IW = $clog2(ENTRIES),
    localparam int TW = PC_W - IW - 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   rd_idx,
    input  logic [TW-1:0]   rd_tag,
    output logic            rd_hit,
    output logic [PC_W-1:0] rd_target,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [TW-1:0]   wr_tag,
    input  logic [PC_W-1:0] wr_target
);
    logic            vld [ENTRIES];
    logic [TW-1:0]   tag [ENTRIES];
    logic [PC_W-1:0] tgt [ENTRIES];

    // Same-cycle lookup with tag comparison.
    assign rd_hit    = vld[rd_idx] && (tag[rd_idx] == rd_tag);
    assign rd_target = tgt[rd_idx];

    // Valid bits: cleared by reset, set on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) vld[i] <= 1'b0;
        end else if (wr_en) begin
            vld[wr_idx] <= 1'b1;
        end
    end

    // Tag and target storage, written on allocation, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag[wr_idx] <= wr_tag;
            tgt[wr_idx] <= wr_target;
        end
    end
endmodule

// File: rtl/bpred_ras.sv
// Circular return-address stack; a push when full overwrites the oldest entry.
// Assumes: DEPTH >= 2; push and pop are never requested together.
module bpred_ras #(
    parameter int DEPTH = 4,
    parameter int PC_W  = 32,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [PC_W-1:0] push_addr,
    input  logic            pop,
    output logic            empty,
    output logic [PC_W-1:0] top
);
    logic [PC_W-1:0] stk [DEPTH];
    logic [PW-1:0]   ptr;   // next free slot
    logic [PW:0]     cnt;   // live entries
    logic [PW-1:0]   ptr_dn;
    logic [PW-1:0]   ptr_up;

    // Wrapped neighbours of the write pointer.
    assign ptr_dn = (ptr == '0) ? PW'(DEPTH - 1) : ptr - 1'b1;
    assign ptr_up = (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    assign empty  = (cnt == '0);
    assign top    = stk[ptr_dn];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            cnt <= '0;
        end else if (push) begin
            ptr <= ptr_up;
            if (cnt != (PW+1)'(DEPTH)) cnt <= cnt + 1'b1;
        end else if (pop && !empty) begin
            ptr <= ptr_dn;
            cnt <= cnt - 1'b1;
        end
    end

    // Return-address storage.
    always_ff @(posedge clk) begin
        if (push) stk[ptr] <= push_addr;
    end
endmodule

// File: rtl/bpred_top.sv
// Fetch-stage branch predictor: counter table, tagged target buffer, return stack.
// Prediction is combinational from fetch_pc; updates land on the next clock edge.
// Assumes 4-byte instructions, so PC bits [1:0] are not used for indexing.
module bpred_top #(
    parameter int PC_W        = 32,
    parameter int DIR_ENTRIES = 256,
    parameter int BTB_ENTRIES = 16,
    parameter int RAS_DEPTH   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic [2:0]      fetch_kind,
    input  logic [PC_W-1:0] fetch_disp,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_target,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [2:0]      upd_kind,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_pred_taken,
    input  logic [PC_W-1:0] upd_pred_target,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc
);
    import bpred_pkg::*;

    localparam int DIR_IW = $clog2(DIR_ENTRIES);
    localparam int BTB_IW = $clog2(BTB_ENTRIES);
    localparam int TAG_W  = PC_W - BTB_IW - 2;

    logic            dir_taken;
    logic            btb_hit;
    logic [PC_W-1:0] btb_target;
    logic            ras_empty;
    logic [PC_W-1:0] ras_top;
    logic [PC_W-1:0] fall_pc;
    logic [PC_W-1:0] direct_pc;
    logic            upd_is_branch;

    assign fall_pc   = fetch_pc + PC_W'(4);
    assign direct_pc = fetch_pc + fetch_disp;
    assign upd_is_branch = (upd_kind == BK_COND) || (upd_kind == BK_JUMP) ||
                           (upd_kind == BK_CALL) || (upd_kind == BK_RET);

    bpred_dir #(.ENTRIES(DIR_ENTRIES)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (fetch_pc[DIR_IW+1:2]),
        .rd_taken (dir_taken),
        .wr_en    (upd_valid && upd_kind == BK_COND),
        .wr_idx   (upd_pc[DIR_IW+1:2]),
        .wr_taken (upd_taken)
    );

    bpred_btb #(.ENTRIES(BTB_ENTRIES), .PC_W(PC_W)) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (fetch_pc[BTB_IW+1:2]),
        .rd_tag    (fetch_pc[PC_W-1:BTB_IW+2]),
        .rd_hit    (btb_hit),
        .rd_target (btb_target),
        .wr_en     (upd_valid && upd_taken && upd_is_branch),
        .wr_idx    (upd_pc[BTB_IW+1:2]),
        .wr_tag    (upd_pc[PC_W-1:BTB_IW+2]),
        .wr_target (upd_target)
    );

    bpred_ras #(.DEPTH(RAS_DEPTH), .PC_W(PC_W)) u_ras (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fetch_valid && fetch_kind == BK_CALL),
        .push_addr (fall_pc),
        .pop       (fetch_valid && fetch_kind == BK_RET),
        .empty     (ras_empty),
        .top       (ras_top)
    );

    // Choose direction and next fetch address from the branch kind.
    always_comb begin
        pred_taken  = 1'b0;
        pred_target = fall_pc;
        case (fetch_kind)
            BK_COND: begin
                pred_taken = btb_hit ? dir_taken : fetch_disp[PC_W-1];
                if (pred_taken) pred_target = btb_hit ? btb_target : direct_pc;
            end
            BK_JUMP, BK_CALL: begin
                pred_taken  = 1'b1;
                pred_target = btb_hit ? btb_target : direct_pc;
            end
            BK_RET: begin
                if (!ras_empty) begin
                    pred_taken  = 1'b1;
                    pred_target = ras_top;
                end else if (btb_hit) begin
                    pred_taken  = 1'b1;
                    pred_target = btb_target;
                end
            end
            default: ;
        endcase
    end

    // Compare the resolved outcome with what was predicted.
    always_comb begin
        redirect_valid = upd_valid &&
                         ((upd_taken != upd_pred_taken) ||
                          (upd_taken && upd_target != upd_pred_target));
        redirect_pc    = upd_taken ? upd_target : upd_pc + PC_W'(4);
    end
endmodule

// File: rtl/bpred_chk.sv
// Cycle-by-cycle property checks on the predictor's ports.
module bpred_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fetch_valid,
    input logic [PC_W-1:0] fetch_pc,
    input logic [2:0]      fetch_kind,
    input logic            pred_taken,
    input logic [PC_W-1:0] pred_target,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken,
    input logic            redirect_valid,
    input logic [PC_W-1:0] redirect_pc
);
    import bpred_pkg::*;

    assert_none_not_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_kind == BK_NONE) |-> !pred_taken);

    assert_uncond_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && (fetch_kind == BK_JUMP || fetch_kind == BK_CALL)) |-> pred_taken);

    assert_not_taken_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !pred_taken) |-> pred_target == fetch_pc + PC_W'(4));

    assert_call_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_kind == BK_RET &&
         $past(fetch_valid) && $past(fetch_kind) == BK_CALL)
        |-> (pred_taken && pred_target == $past(fetch_pc) + PC_W'(4)));

    assert_redirect_needs_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> upd_valid);

    assert_redirect_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !upd_taken) |-> redirect_pc == upd_pc + PC_W'(4));
endmodule

bind bpred_top bpred_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/sim_bpred_top.sv
`timescale 1ns/1ps
module sim_bpred_top;
    localparam int DIR_N = 256;
    localparam int BTB_N = 16;
    localparam int RAS_N = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_valid;
    logic [31:0] fetch_pc, fetch_disp;
    logic [2:0]  fetch_kind;
    logic        pred_taken;
    logic [31:0] pred_target;
    logic        upd_valid, upd_taken, upd_pred_taken;
    logic [31:0] upd_pc, upd_target, upd_pred_target;
    logic [2:0]  upd_kind;
    logic        redirect_valid;
    logic [31:0] redirect_pc;

    always #4 clk = ~clk;

    bpred_top u0 (.*);

    int n_chk = 0;
    int n_fail = 0;

    // Independent reference state.
    logic [1:0]  m_ctr [DIR_N];
    logic        m_v   [BTB_N];
    logic [31:0] m_bpc [BTB_N];
    logic [31:0] m_tgt [BTB_N];
    logic [31:0] m_ras [$];

    function automatic int bidx(input logic [31:0] pc);
        return int'((pc >> 2) % BTB_N);
    endfunction

    function automatic logic bhit(input logic [31:0] pc);
        return m_v[bidx(pc)] && ((m_bpc[bidx(pc)] >> 6) == (pc >> 6));
    endfunction

    function automatic void model_pred(input logic [2:0] k, input logic [31:0] pc, d,
                                       output logic t, output logic [31:0] tg);
        logic h;
        h  = bhit(pc);
        t  = 1'b0;
        tg = pc + 4;
        case (k)
            3'd1: begin
                t = h ? m_ctr[int'((pc >> 2) % DIR_N)][1] : d[31];
                if (t) tg = h ? m_tgt[bidx(pc)] : pc + d;
            end
            3'd2, 3'd3: begin t = 1'b1; tg = h ? m_tgt[bidx(pc)] : pc + d; end
            3'd4: begin
                if (m_ras.size() > 0) begin t = 1'b1; tg = m_ras[m_ras.size()-1]; end
                else if (h) begin t = 1'b1; tg = m_tgt[bidx(pc)]; end
            end
            default: ;
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: drive, check combinational outputs, then commit the model.
    task automatic step(input logic fv, input logic [2:0] fk, input logic [31:0] fpc, fd,
                        input logic uv, input logic [2:0] uk, input logic [31:0] upc,
                        input logic ut, input logic [31:0] utg,
                        input logic upt, input logic [31:0] uptg, input string req);
        logic        et, er;
        logic [31:0] eg, erp;
        int          di;
        @(negedge clk);
        fetch_valid = fv; fetch_kind = fk; fetch_pc = fpc; fetch_disp = fd;
        upd_valid = uv; upd_kind = uk; upd_pc = upc; upd_taken = ut;
        upd_target = utg; upd_pred_taken = upt; upd_pred_target = uptg;
        #1;
        if (fv) begin
            model_pred(fk, fpc, fd, et, eg);
            chk(pred_taken == et, req, "pred_taken", 32'(pred_taken), 32'(et));
            chk(pred_target == eg, req, "pred_target", pred_target, eg);
        end
        er  = uv && ((ut != upt) || (ut && utg != uptg));
        erp = ut ? utg : upc + 4;
        chk(redirect_valid == er, req, "redirect_valid", 32'(redirect_valid), 32'(er));
        if (er) chk(redirect_pc == erp, req, "redirect_pc", redirect_pc, erp);
        // Commit fetch side effects.
        if (fv && fk == 3'd3) begin
            m_ras.push_back(fpc + 4);
            if (m_ras.size() > RAS_N) void'(m_ras.pop_front());
        end else if (fv && fk == 3'd4 && m_ras.size() > 0) begin
            void'(m_ras.pop_back());
        end
        // Commit update side effects.
        if (uv && uk == 3'd1) begin
            di = int'((upc >> 2) % DIR_N);
            if (ut && m_ctr[di] != 2'd3) m_ctr[di] = m_ctr[di] + 2'd1;
            if (!ut && m_ctr[di] != 2'd0) m_ctr[di] = m_ctr[di] - 2'd1;
        end
        if (uv && ut && uk >= 3'd1 && uk <= 3'd4) begin
            m_v[bidx(upc)] = 1'b1; m_bpc[bidx(upc)] = upc; m_tgt[bidx(upc)] = utg;
        end
    endtask

    task automatic fetch(input logic [2:0] k, input logic [31:0] pc, d, input string req);
        step(1'b1, k, pc, d, 1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, req);
    endtask

    task automatic upd(input logic [2:0] k, input logic [31:0] pc, input logic t,
                       input logic [31:0] tg, input string req);
        step(1'b0, 3'd0, 32'h0, 32'h0, 1'b1, k, pc, t, tg, t, tg, req);
    endtask

    function automatic logic [31:0] rpc();
        return 32'h3000 + 32'(4 * ($urandom % 24));
    endfunction

    function automatic logic [31:0] rdisp();
        logic [31:0] m;
        m = 32'(4 * (($urandom % 8) + 1));
        return ($urandom % 2) ? -m : m;
    endfunction

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < DIR_N; i++) m_ctr[i] = 2'b01;
        for (int i = 0; i < BTB_N; i++) begin m_v[i] = 1'b0; m_bpc[i] = '0; m_tgt[i] = '0; end
        rst_n = 1'b0;
        fetch_valid = 0; fetch_kind = 0; fetch_pc = 0; fetch_disp = 0;
        upd_valid = 0; upd_kind = 0; upd_pc = 0; upd_taken = 0;
        upd_target = 0; upd_pred_taken = 0; upd_pred_target = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 / R10: reset state, no-branch fetch.
        fetch(3'd0, 32'h100, 32'h0, "R10");
        chk(pred_taken == 1'b0 && pred_target == 32'h104, "R1", "reset none",
            pred_target, 32'h104);
        // R2: static fallback on a miss.
        fetch(3'd1, 32'h100, 32'h20, "R2");
        fetch(3'd1, 32'h100, -32'h10, "R2");
        chk(pred_taken && pred_target == 32'hF0, "R2", "backward taken", pred_target, 32'hF0);
        // R1: a single taken update flips a weakly not-taken counter.
        upd(3'd1, 32'h500, 1'b1, 32'h600, "R1");
        fetch(3'd1, 32'h500, 32'h8, "R1");
        chk(pred_taken && pred_target == 32'h600, "R1", "one taken", pred_target, 32'h600);
        // R3 / R4: hysteresis and saturation.
        upd(3'd1, 32'h200, 1'b1, 32'h300, "R3");
        upd(3'd1, 32'h200, 1'b1, 32'h300, "R3");
        upd(3'd1, 32'h200, 1'b0, 32'h300, "R4");
        fetch(3'd1, 32'h200, 32'h8, "R4");
        chk(pred_taken == 1'b1, "R4", "one contrary outcome", 32'(pred_taken), 32'd1);
        upd(3'd1, 32'h200, 1'b0, 32'h300, "R4");
        fetch(3'd1, 32'h200, -32'h8, "R4");
        upd(3'd1, 32'h200, 1'b0, 32'h300, "R3");
        upd(3'd1, 32'h200, 1'b0, 32'h300, "R3");
        upd(3'd1, 32'h200, 1'b1, 32'h300, "R3");
        fetch(3'd1, 32'h200, -32'h8, "R3");
        chk(pred_taken == 1'b0 && pred_target == 32'h204, "R3", "saturated low",
            pred_target, 32'h204);
        // R5: tag alias with the same buffer index is a miss.
        fetch(3'd1, 32'h240, 32'h10, "R5");
        chk(pred_taken == 1'b0, "R5", "alias miss", 32'(pred_taken), 32'd0);
        // R6: jumps.
        fetch(3'd2, 32'h400, 32'h40, "R6");
        upd(3'd2, 32'h400, 1'b1, 32'h800, "R6");
        fetch(3'd2, 32'h400, 32'h40, "R6");
        chk(pred_target == 32'h800, "R6", "jump hit", pred_target, 32'h800);
        // R7 / R8: nested calls beyond the stack depth, then returns.
        for (int i = 0; i < RAS_N + 1; i++) fetch(3'd3, 32'h1000 + 32'(16 * i), 32'h400, "R7");
        for (int i = 0; i < RAS_N + 1; i++) fetch(3'd4, 32'h2000, 32'h0, "R8");
        chk(pred_taken == 1'b0 && pred_target == 32'h2004, "R8", "empty return",
            pred_target, 32'h2004);
        fetch(3'd3, 32'h1100, 32'h40, "R7");
        fetch(3'd0, 32'h1104, 32'h0, "R10");
        fetch(3'd4, 32'h2000, 32'h0, "R10");
        chk(pred_target == 32'h1104, "R10", "none keeps stack", pred_target, 32'h1104);
        // R9: redirects.
        step(1'b0, 3'd0, 0, 0, 1'b1, 3'd1, 32'h700, 1'b0, 32'h900, 1'b1, 32'h900, "R9");
        step(1'b0, 3'd0, 0, 0, 1'b1, 3'd2, 32'h700, 1'b1, 32'h940, 1'b1, 32'h900, "R9");
        step(1'b0, 3'd0, 0, 0, 1'b1, 3'd1, 32'h700, 1'b1, 32'h940, 1'b1, 32'h940, "R9");

        // Random mix against the model.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] tg;
            tg = 32'h8000 + 32'(4 * ($urandom % 64));
            step(1'($urandom % 4 != 0), 3'($urandom % 5), rpc(), rdisp(),
                 1'($urandom % 2), 3'($urandom % 5), rpc(), 1'($urandom % 2), tg,
                 1'($urandom % 2), ($urandom % 2) ? tg : 32'h8000 + 32'(4 * ($urandom % 64)),
                 "R3 R5 R7 R9 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule